// File: doc/BRIEF.md
# Egress Timestamp Capture Register

This block holds one egress timestamp per switch port. When a frame leaves port `p`, the port's egress strobe is pulsed for one cycle. The block then stores the low bits of the free-running cycle counter for that port and raises the port's "fresh" flag. Software polls the block through a word-addressed read interface. It reads the word that holds the fresh flag until the flag is set, and it gives up after ten unsuccessful polls. It then fetches the stamp. Rebuilding the full-width time from the partial stamp is done elsewhere.

A parameter selects one of two packed layouts:

- **Compact layout:** one 32-bit word. The 24-bit stamp sits in bits 31:8 and the fresh flag in bit 0.
- **Wide layout:** two 32-bit words. Word 0 carries only the fresh flag in bit 0, and word 1 carries the full 32-bit stamp.

In both layouts the flag is at bit 0 of word 0, so a poller can use the same code for either one. Reading the word that carries the stamp consumes the flag.

Top module: `egts_capture`

## Requirements
- R1: While reset is high, and in the cycle after it, every port's fresh flag is 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: A pulse on `egress_evt[p]` stores `cyc_cnt` (the low TS_W counter bits; TS_W is 24 compact, 32 wide) for port p and sets its fresh flag at that clock edge.
- R3: Compact layout (LONG_LAYOUT=0): word 0 returns {stamp[23:0], 7'b0, fresh}; word 1 returns all zeros.
- R4: Wide layout (LONG_LAYOUT=1): word 0 returns {31'b0, fresh}; word 1 returns the 32-bit stamp.
- R5: A read request (`rd_req`, `rd_port`, `rd_word`) sampled at an edge produces `rd_valid`=1 and the data in the following cycle. The data reflects the state from before that edge.
- R6: Reading the stamp-bearing word clears that port's fresh flag. This is word 0 in the compact layout and word 1 in the wide layout. Reading word 0 in the wide layout leaves the flag unchanged.
- R7: If a capture and a clearing read hit the same port in the same cycle, the capture wins: the flag stays set and the new stamp is stored. The read still returns the old contents.
- R8: A capture on a port whose flag is already set overwrites the stored stamp with the new counter value.
- R9: Ports are independent: captures and reads on one port never change another port's stamp or flag.
- R10: A read of `rd_port` >= NUM_PORTS returns all zeros and changes no port's state.
- R11: Whenever `rd_valid` is 0, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_cnt | input | TS_W | Low bits of the free-running cycle counter |
| egress_evt | input | NUM_PORTS | One-cycle capture strobe per port |
| rd_req | input | 1 | Read request |
| rd_port | input | PORT_W | Port to read |
| rd_word | input | 1 | Word select: 0 for the flag word, 1 for the second word |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 32 | Packed read word |

## Verification
A flag stuck high or cleared by the wrong word shows at bit 0 of word 0 on the very next poll of that port. A stamp latched from the wrong cycle or the wrong port shows as a value mismatch on the next read of the stamp-bearing word. Layout errors show as nonzero reserved bits, or as a misplaced stamp in the first read after a capture. The bench runs both layouts side by side on the same stimulus. It sweeps every capture mask against every port and word, including simultaneous capture and read, so that a fault shows within one read cycle of where it arises.

// File: rtl/egts_pkg.sv
package egts_pkg;

    // Word select on the read interface.
    typedef enum logic {
        WSEL_FLAG = 1'b0,
        WSEL_HIGH = 1'b1
    } word_sel_e;

    // Per-port stored state. The stamp is kept at full 32-bit width and
    // only its low 24 bits are used in the compact layout.
    typedef struct packed {
        logic        fresh;
        logic [31:0] stamp;
    } slot_state_t;

    localparam slot_state_t SLOT_IDLE = '{fresh: 1'b0, stamp: 32'h0};

    // Build the packed read word for one port and one word select.
    function automatic logic [31:0] pack_word(input bit long_fmt,
                                              input logic wsel,
                                              input slot_state_t s);
        logic [31:0] w;
        if (long_fmt) begin
            w = (wsel == WSEL_HIGH) ? s.stamp : {31'h0, s.fresh};
        end else begin
            w = (wsel == WSEL_HIGH) ? 32'h0 : {s.stamp[23:0], 7'h0, s.fresh};
        end
        return w;
    endfunction

    // The word whose read consumes the fresh flag.
    function automatic logic consuming_word(input bit long_fmt);
        return long_fmt ? WSEL_HIGH : WSEL_FLAG;
    endfunction

endpackage

// File: rtl/egts_slot.sv
module egts_slot
    import egts_pkg::*;
#(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic [TS_W-1:0] stamp_in,
    input  logic            consume,
    output slot_state_t     state
);

    slot_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SLOT_IDLE;
        end else if (capture) begin
            // A capture wins over a consuming read in the same cycle.
            st_q.fresh <= 1'b1;
            st_q.stamp <= 32'(stamp_in);
        end else if (consume) begin
            st_q.fresh <= 1'b0;
        end
    end

    assign state = st_q;

endmodule

// File: rtl/egts_read_port.sv
module egts_read_port
    import egts_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter bit LONG_LAYOUT = 1'b1,
    parameter int PORT_W      = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_req,
    input  logic [PORT_W-1:0]           rd_port,
    input  logic                        rd_word,
    input  slot_state_t [NUM_PORTS-1:0] slots,
    output logic [NUM_PORTS-1:0]        consume,
    output logic                        rd_valid,
    output logic [31:0]                 rd_data
);

    localparam logic CLR_WORD = consuming_word(LONG_LAYOUT);

    slot_state_t sel_state;
    logic        sel_hit;
    logic [31:0] next_word;

    always_comb begin
        sel_state = SLOT_IDLE;
        sel_hit   = 1'b0;
        consume   = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (rd_port == PORT_W'(i)) begin
                sel_state  = slots[i];
                sel_hit    = 1'b1;
                consume[i] = rd_req && (rd_word == CLR_WORD);
            end
        end
        next_word = sel_hit ? pack_word(LONG_LAYOUT, rd_word, sel_state) : 32'h0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= 32'h0;
        end else begin
            rd_valid <= rd_req;
            rd_data  <= rd_req ? next_word : 32'h0;
        end
    end

endmodule

// File: rtl/egts_capture.sv
module egts_capture
    import egts_pkg::*;
#(
    parameter int  NUM_PORTS   = 4,
    parameter bit  LONG_LAYOUT = 1'b1,
    localparam int TS_W        = LONG_LAYOUT ? 32 : 24,
    localparam int PORT_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [TS_W-1:0]      cyc_cnt,
    input  logic [NUM_PORTS-1:0] egress_evt,
    input  logic                 rd_req,
    input  logic [PORT_W-1:0]    rd_port,
    input  logic                 rd_word,
    output logic                 rd_valid,
    output logic [31:0]          rd_data
);

    slot_state_t [NUM_PORTS-1:0] slots;
    logic        [NUM_PORTS-1:0] consume;
    logic        [NUM_PORTS-1:0] upd_vec;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slot
        egts_slot #(.TS_W(TS_W)) slot_i (
            .clk      (clk),
            .rst      (rst),
            .capture  (egress_evt[p]),
            .stamp_in (cyc_cnt),
            .consume  (consume[p]),
            .state    (slots[p])
        );
        assign upd_vec[p] = slots[p].fresh;
    end

    egts_read_port #(
        .NUM_PORTS   (NUM_PORTS),
        .LONG_LAYOUT (LONG_LAYOUT),
        .PORT_W      (PORT_W)
    ) rdp_i (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (rd_req),
        .rd_port  (rd_port),
        .rd_word  (rd_word),
        .slots    (slots),
        .consume  (consume),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/egts_capture_chk.sv
module egts_capture_chk #(
    parameter int NUM_PORTS   = 4,
    parameter bit LONG_LAYOUT = 1'b1,
    parameter int PORT_W      = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_PORTS-1:0] egress_evt,
    input logic                 rd_req,
    input logic [PORT_W-1:0]    rd_port,
    input logic                 rd_word,
    input logic                 rd_valid,
    input logic [31:0]          rd_data,
    input logic [NUM_PORTS-1:0] upd_vec
);

    localparam logic CLR_WORD = LONG_LAYOUT ? 1'b1 : 1'b0;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (upd_vec == '0 && !rd_valid && rd_data == 32'h0));

    // R5
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    // R5
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> rd_data == 32'h0);

    // R2, R7
    capture_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (|egress_evt) |=> ((upd_vec & $past(egress_evt)) == $past(egress_evt)));

    // R6
    read_consumes_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_word == CLR_WORD && int'(rd_port) < NUM_PORTS
         && (egress_evt == '0)) |=> !upd_vec[$past(rd_port)]);

    if (LONG_LAYOUT) begin : g_wide
        // R4
        flag_word_clean_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_valid && !$past(rd_word)) |-> rd_data[31:1] == 31'h0);
    end else begin : g_compact
        // R3
        reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
            rd_valid |-> rd_data[7:1] == 7'h0);
        // R3
        high_word_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_valid && $past(rd_word)) |-> rd_data == 32'h0);
    end

endmodule

bind egts_capture egts_capture_chk #(
    .NUM_PORTS   (NUM_PORTS),
    .LONG_LAYOUT (LONG_LAYOUT),
    .PORT_W      (PORT_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .egress_evt (egress_evt),
    .rd_req     (rd_req),
    .rd_port    (rd_port),
    .rd_word    (rd_word),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .upd_vec    (upd_vec)
);

// File: tb/egts_capture_tb.sv
module egts_capture_tb_top;

    localparam int NP = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cnt = '0;
    logic [NP-1:0] evt = '0;
    logic        req = 1'b0;
    logic [1:0]  port = '0;
    logic        word = 1'b0;
    logic        vld_s, vld_l;
    logic [31:0] dat_s, dat_l;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Bench model, built from the requirements.
    logic [31:0] m_ts  [NP];
    logic        m_upd_s [NP];
    logic        m_upd_l [NP];

    always #5 clk = ~clk;

    egts_capture #(.NUM_PORTS(NP), .LONG_LAYOUT(1'b0)) dut_i (
        .clk(clk), .rst(rst), .cyc_cnt(cnt[23:0]), .egress_evt(evt),
        .rd_req(req), .rd_port(port), .rd_word(word),
        .rd_valid(vld_s), .rd_data(dat_s)
    );

    egts_capture #(.NUM_PORTS(NP), .LONG_LAYOUT(1'b1)) dut_l_i (
        .clk(clk), .rst(rst), .cyc_cnt(cnt), .egress_evt(evt),
        .rd_req(req), .rd_port(port), .rd_word(word),
        .rd_valid(vld_l), .rd_data(dat_l)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_short(input int p, input logic w);
        if (p >= NP || w) return 32'h0;
        return {m_ts[p][23:0], 7'h0, m_upd_s[p]};
    endfunction

    function automatic logic [31:0] exp_long(input int p, input logic w);
        if (p >= NP) return 32'h0;
        return w ? m_ts[p] : {31'h0, m_upd_l[p]};
    endfunction

    // Drive one cycle at the falling edge, then check at the next one.
    task automatic step(input string tag, input logic [NP-1:0] e, input logic r,
                        input int p, input logic w, input logic [31:0] c);
        logic [31:0] xs, xl;
        evt = e; req = r; port = 2'(p); word = w; cnt = c;
        xs = r ? exp_short(p, w) : 32'h0;
        xl = r ? exp_long(p, w)  : 32'h0;
        for (int i = 0; i < NP; i++) begin
            if (e[i]) begin
                m_ts[i] = c; m_upd_s[i] = 1'b1; m_upd_l[i] = 1'b1;
            end else if (r && p == i) begin
                if (!w) m_upd_s[i] = 1'b0;
                if (w)  m_upd_l[i] = 1'b0;
            end
        end
        @(negedge clk);
        check("R5 valid short", 32'(vld_s), 32'(r));
        check("R5 valid wide",  32'(vld_l), 32'(r));
        check({tag, " short"}, dat_s, xs);
        check({tag, " wide"},  dat_l, xl);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NP; i++) begin
            m_ts[i] = '0; m_upd_s[i] = 1'b0; m_upd_l[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        check("R1 valid", 32'(vld_s | vld_l), 32'h0);
        check("R1 data", dat_s | dat_l, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        // R1: all flags clear after reset
        for (int p = 0; p < NP; p++)
            for (int w = 0; w < 2; w++)
                step("R1 read", '0, 1'b1, p, 1'(w), 32'h0);

        // R2: one capture per port with distinct counter values
        for (int p = 0; p < NP; p++)
            step("R2 capture", NP'(1 << p), 1'b0, 0, 1'b0, 32'hC0DE_0000 + 32'(p * 32'h0101_0101));
        // R11: idle cycle, no read
        step("R11 idle", '0, 1'b0, 0, 1'b0, 32'h0);
        // R3 / R4: read every word of every port, including out of range
        for (int p = 0; p < 4; p++)
            for (int w = 0; w < 2; w++)
                step("R3/R4 layout", '0, 1'b1, p, 1'(w), 32'h0);

        // R6: wide flag-word reads do not consume; compact reads do
        step("R2 capture", 3'b010, 1'b0, 0, 1'b0, 32'h1234_5678);
        step("R6 first", '0, 1'b1, 1, 1'b0, 32'h0);
        step("R6 again", '0, 1'b1, 1, 1'b0, 32'h0);
        step("R6 stamp", '0, 1'b1, 1, 1'b1, 32'h0);
        step("R6 after", '0, 1'b1, 1, 1'b0, 32'h0);

        // R8: overwrite while still fresh
        step("R8 first", 3'b001, 1'b0, 0, 1'b0, 32'hAAAA_AAAA);
        step("R8 second", 3'b001, 1'b0, 0, 1'b0, 32'h5555_5555);
        step("R8 read flag", '0, 1'b1, 0, 1'b0, 32'h0);
        step("R8 read stamp", '0, 1'b1, 0, 1'b1, 32'h0);

        // R7: capture and consuming read on the same port in one cycle
        step("R7 collide w0", 3'b100, 1'b1, 2, 1'b0, 32'h0BAD_F00D);
        step("R7 collide w1", 3'b100, 1'b1, 2, 1'b1, 32'h0FEE_D123);
        step("R7 after", '0, 1'b1, 2, 1'b0, 32'h0);
        step("R7 stamp", '0, 1'b1, 2, 1'b1, 32'h0);

        // R9: consume ports 0 and 1, port 2 keeps its state
        step("R9 set2", 3'b100, 1'b0, 0, 1'b0, 32'h7777_1111);
        for (int p = 0; p < 2; p++)
            for (int w = 0; w < 2; w++)
                step("R9 other", '0, 1'b1, p, 1'(w), 32'h0);
        step("R9 kept", '0, 1'b1, 2, 1'b0, 32'h0);

        // R10: out-of-range reads return zero and touch nothing
        step("R9 set0", 3'b001, 1'b0, 0, 1'b0, 32'h00AB_CDEF);
        step("R10 oob w0", '0, 1'b1, 3, 1'b0, 32'h0);
        step("R10 oob w1", '0, 1'b1, 3, 1'b1, 32'h0);
        step("R10 intact", '0, 1'b1, 0, 1'b0, 32'h0);

        // Sweep: every capture mask against every port and word
        for (int m = 0; m < 8; m++)
            for (int p = 0; p < 4; p++)
                for (int w = 0; w < 2; w++) begin
                    step("R2 sweep cap", NP'(m), 1'b0, 0, 1'b0,
                         32'(m * 32'h1357_9BDF + p * 32'h0F0F + w));
                    step("R7 sweep", NP'((m + p) % 8), 1'b1, p, 1'(w),
                         32'(m * 32'h0246_8ACE + p));
                    step("R3/R4 sweep", '0, 1'b1, p, 1'(w), 32'h0);
                    step("R11 sweep idle", '0, 1'b0, 0, 1'b0, 32'h0);
                end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule